// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 interrupt request lines into a fast request output and a normal request output. A class register routes each source to one output or the other, and an enable register masks it. A software register is ORed onto the hardware lines, so firmware can raise any source itself. Enable bits and software bits are set by writing ones to one register and cleared by writing ones to a second register. Firmware therefore never needs a read-modify-write to change them.

For the normal class there are 16 vector slots. Each slot names one source and holds the address of its handler. A read of the vector register returns the handler address of the most urgent pending slot. If no slot matches, the read returns a default address. A successful vector read also holds that slot as in service, so that only more urgent slots can displace it. A write of any value to the vector register ends the service and drops the hold. A guard bit can limit all register access to bus cycles that carry the privileged flag. The register bus is synchronous: read data appears one cycle after the read strobe.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads 0, `fiq_n` and `irq_n` are 1, and `bus_rdata` is 0.
- R2: Offset 0x008 reads `irq_req | software register`, whatever the enable and class bits hold. Writes to 0x008, 0x000 and 0x004 change nothing.
- R3: Class register 0x00C: a 1 in bit i makes source i fast, and a 0 makes it normal. Offset 0x004 reads raw & enable & class. Offset 0x000 reads raw & enable & ~class.
- R4: A write to 0x010 sets the enable bits where the data has ones and leaves the other bits unchanged. Reading 0x010 returns the enable bits. A write to 0x014 clears the enable bits where the data has ones.
- R5: A write to 0x018 sets software bits where the data has ones. Reading 0x018 returns them. A write to 0x01C clears software bits where the data has ones.
- R6: `fiq_n` is 0 exactly when the fast status was nonzero at the previous clock edge. `irq_n` is 0 exactly when the normal status was nonzero at the previous clock edge.
- R7: Slot n has a handler address register at 0x100+4n (32 bits) and a control register at 0x200+4n. The control register holds the source number in bits 4:0 and the slot enable in bit 5. Both read back as written, and the control register's other bits read 0.
- R8: A slot is eligible when it is enabled, its source's normal-status bit is set, and (if a hold exists) its index is below the held index. A read of 0x030 returns the address of the eligible slot with the lowest index. If no slot is eligible, it returns the held slot's address. If no slot is eligible and there is no hold, it returns the default address at 0x034.
- R9: A permitted read of 0x030 that finds an eligible slot makes that slot the held slot.
- R10: A permitted write of any value to 0x030 drops the hold.
- R11: Guard bit 0 of 0x020 is the protection bit. While it is 1, an access with `bus_priv` = 0 is blocked: its write changes no register and its read returns 0.
- R12: `bus_rdata` shows the addressed value in the cycle after `bus_rd` and is 0 otherwise. Write-only (0x014, 0x01C) and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 32 | Hardware request lines, active high |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | The access is privileged |
| bus_rdata | output | 32 | Read data, registered |
| fiq_n | output | 1 | Fast request, active low |
| irq_n | output | 1 | Normal request, active low |

## Verification
A wrong class, enable or software bit appears on `fiq_n` or `irq_n` one edge after it is stored. It also appears in the next read of the status offsets. A corrupted slot table or priority encoder appears only at the next vector read, so the bench interleaves vector reads with random request patterns. A lost or stale hold appears on the first vector read after a more urgent or a less urgent source rises. End-of-service writes are mixed in so that a hold that is never released is caught within a few reads.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int OFS_IRQ_STAT  = 'h000;
  localparam int OFS_FIQ_STAT  = 'h004;
  localparam int OFS_RAW       = 'h008;
  localparam int OFS_CLASS     = 'h00C;
  localparam int OFS_EN_SET    = 'h010;
  localparam int OFS_EN_CLR    = 'h014;
  localparam int OFS_SW_SET    = 'h018;
  localparam int OFS_SW_CLR    = 'h01C;
  localparam int OFS_GUARD     = 'h020;
  localparam int OFS_VEC       = 'h030;
  localparam int OFS_DEFAULT   = 'h034;
  localparam int OFS_SLOT_ADDR = 'h100;
  localparam int OFS_SLOT_CTL  = 'h200;
endpackage

// File: rtl/ivc_src_regs.sv
module ivc_src_regs #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] wdata,
  input  logic             we_class,
  input  logic             we_en_set,
  input  logic             we_en_clr,
  input  logic             we_sw_set,
  input  logic             we_sw_clr,
  output logic [N_SRC-1:0] cls_q,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] sw_q,
  output logic [N_SRC-1:0] raw,
  output logic [N_SRC-1:0] fst,
  output logic [N_SRC-1:0] ist
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cls_q <= '0;
      en_q  <= '0;
      sw_q  <= '0;
    end else begin
      if (we_class)  cls_q <= wdata;
      if (we_en_set) en_q  <= en_q | wdata;
      if (we_en_clr) en_q  <= en_q & ~wdata;
      if (we_sw_set) sw_q  <= sw_q | wdata;
      if (we_sw_clr) sw_q  <= sw_q & ~wdata;
    end
  end

  assign raw = req | sw_q;
  assign fst = raw & en_q & cls_q;
  assign ist = raw & en_q & ~cls_q;

  AST_EN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    we_en_clr |=> (en_q & $past(wdata)) == '0); // R4
  AST_SW_CLEARED: assert property (@(posedge clk) disable iff (rst)
    we_sw_clr |=> (sw_q & $past(wdata)) == '0); // R5
endmodule

// File: rtl/ivc_vec_table.sv
module ivc_vec_table #(
  parameter int N_SLOT = 16,
  parameter int N_SRC  = 32,
  parameter int DW     = 32,
  parameter int SLW    = 4,
  parameter int SRCW   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SLOT-1:0] addr_we,
  input  logic [N_SLOT-1:0] ctl_we,
  input  logic [DW-1:0]     wdata,
  input  logic [N_SRC-1:0]  ist,
  input  logic              hold_valid,
  input  logic [SLW-1:0]    hold_slot,
  input  logic [SLW-1:0]    rd_idx_a,
  input  logic [SLW-1:0]    rd_idx_c,
  output logic [DW-1:0]     rd_addr,
  output logic [SRCW:0]     rd_ctl,
  output logic [DW-1:0]     held_addr,
  output logic              win_any,
  output logic [SLW-1:0]    win_idx,
  output logic [DW-1:0]     win_addr
);
  logic [DW-1:0] slot_addr [N_SLOT];
  logic [SRCW:0] slot_ctl  [N_SLOT];
  logic [N_SLOT-1:0] elig;
  logic [N_SLOT-1:0] grant;
  logic [N_SLOT:0]   seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_SLOT; i++) begin
        slot_addr[i] <= '0;
        slot_ctl[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N_SLOT; i++) begin
        if (addr_we[i]) slot_addr[i] <= wdata;
        if (ctl_we[i])  slot_ctl[i]  <= wdata[SRCW:0];
      end
    end
  end

  assign seen[0] = 1'b0;
  for (genvar n = 0; n < N_SLOT; n++) begin : g_slot
    assign elig[n]  = slot_ctl[n][SRCW] & ist[slot_ctl[n][SRCW-1:0]]
                      & (~hold_valid | (SLW'(n) < hold_slot));
    assign grant[n] = elig[n] & ~seen[n];
    assign seen[n+1] = seen[n] | elig[n];
  end

  assign win_any = seen[N_SLOT];

  always_comb begin
    win_idx = '0;
    for (int i = N_SLOT - 1; i >= 0; i--)
      if (elig[i]) win_idx = SLW'(i);
  end

  assign win_addr  = slot_addr[win_idx];
  assign held_addr = slot_addr[hold_slot];
  assign rd_addr   = slot_addr[rd_idx_a];
  assign rd_ctl    = slot_ctl[rd_idx_c];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R8
  AST_WIN_IS_GRANTED: assert property (@(posedge clk) disable iff (rst)
    win_any |-> grant[win_idx]); // R8
  AST_HOLD_PRIO: assert property (@(posedge clk) disable iff (rst)
    (hold_valid && win_any) |-> (win_idx < hold_slot)); // R9
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl import ivc_pkg::*; #(
  parameter int N_SRC  = 32,
  parameter int N_SLOT = 16,
  parameter int DW     = 32,
  parameter int AW     = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_priv,
  output logic [DW-1:0]    bus_rdata,
  output logic             fiq_n,
  output logic             irq_n
);
  localparam int SLW  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;
  localparam int SRCW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int SPAN = 4 * N_SLOT;

  logic             guard_q;
  logic [DW-1:0]    def_q;
  logic             hold_valid;
  logic [SLW-1:0]   hold_slot;
  logic             acc_ok, wr_ok, rd_ok;
  logic [AW-1:0]    off_a, off_c;
  logic             in_sa, in_sc;
  logic [SLW-1:0]   idx_a, idx_c;
  logic [N_SLOT-1:0] addr_we, ctl_we;
  logic [N_SRC-1:0] cls_q, en_q, sw_q, raw, fst, ist;
  logic [DW-1:0]    rd_addr, held_addr, win_addr, vec_val, rd_next;
  logic [SRCW:0]    rd_ctl;
  logic             win_any;
  logic [SLW-1:0]   win_idx;
  logic             hit_vec;

  assign acc_ok  = ~guard_q | bus_priv;
  assign wr_ok   = bus_wr & acc_ok;
  assign rd_ok   = bus_rd & acc_ok;
  assign hit_vec = (bus_addr == AW'(OFS_VEC));

  assign off_a = bus_addr - AW'(OFS_SLOT_ADDR);
  assign off_c = bus_addr - AW'(OFS_SLOT_CTL);
  assign in_sa = (off_a < AW'(SPAN)) && (off_a[1:0] == 2'b00);
  assign in_sc = (off_c < AW'(SPAN)) && (off_c[1:0] == 2'b00);
  assign idx_a = off_a[SLW+1:2];
  assign idx_c = off_c[SLW+1:2];

  for (genvar n = 0; n < N_SLOT; n++) begin : g_we
    assign addr_we[n] = wr_ok & in_sa & (idx_a == SLW'(n));
    assign ctl_we[n]  = wr_ok & in_sc & (idx_c == SLW'(n));
  end

  ivc_src_regs #(.N_SRC(N_SRC)) u_src (
    .clk       (clk),
    .rst       (rst),
    .req       (irq_req),
    .wdata     (bus_wdata[N_SRC-1:0]),
    .we_class  (wr_ok && bus_addr == AW'(OFS_CLASS)),
    .we_en_set (wr_ok && bus_addr == AW'(OFS_EN_SET)),
    .we_en_clr (wr_ok && bus_addr == AW'(OFS_EN_CLR)),
    .we_sw_set (wr_ok && bus_addr == AW'(OFS_SW_SET)),
    .we_sw_clr (wr_ok && bus_addr == AW'(OFS_SW_CLR)),
    .cls_q     (cls_q),
    .en_q      (en_q),
    .sw_q      (sw_q),
    .raw       (raw),
    .fst       (fst),
    .ist       (ist)
  );

  ivc_vec_table #(
    .N_SLOT(N_SLOT), .N_SRC(N_SRC), .DW(DW), .SLW(SLW), .SRCW(SRCW)
  ) u_tab (
    .clk        (clk),
    .rst        (rst),
    .addr_we    (addr_we),
    .ctl_we     (ctl_we),
    .wdata      (bus_wdata),
    .ist        (ist),
    .hold_valid (hold_valid),
    .hold_slot  (hold_slot),
    .rd_idx_a   (idx_a),
    .rd_idx_c   (idx_c),
    .rd_addr    (rd_addr),
    .rd_ctl     (rd_ctl),
    .held_addr  (held_addr),
    .win_any    (win_any),
    .win_idx    (win_idx),
    .win_addr   (win_addr)
  );

  assign vec_val = win_any ? win_addr : (hold_valid ? held_addr : def_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q    <= 1'b0;
      def_q      <= '0;
      hold_valid <= 1'b0;
      hold_slot  <= '0;
    end else begin
      if (wr_ok && bus_addr == AW'(OFS_GUARD))   guard_q <= bus_wdata[0];
      if (wr_ok && bus_addr == AW'(OFS_DEFAULT)) def_q   <= bus_wdata;
      if (rd_ok && hit_vec && win_any) begin
        hold_valid <= 1'b1;
        hold_slot  <= win_idx;
      end
      if (wr_ok && hit_vec) hold_valid <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      AW'(OFS_IRQ_STAT): rd_next[N_SRC-1:0] = ist;
      AW'(OFS_FIQ_STAT): rd_next[N_SRC-1:0] = fst;
      AW'(OFS_RAW):      rd_next[N_SRC-1:0] = raw;
      AW'(OFS_CLASS):    rd_next[N_SRC-1:0] = cls_q;
      AW'(OFS_EN_SET):   rd_next[N_SRC-1:0] = en_q;
      AW'(OFS_SW_SET):   rd_next[N_SRC-1:0] = sw_q;
      AW'(OFS_GUARD):    rd_next[0]         = guard_q;
      AW'(OFS_VEC):      rd_next            = vec_val;
      AW'(OFS_DEFAULT):  rd_next            = def_q;
      default: begin
        if (in_sa)      rd_next          = rd_addr;
        else if (in_sc) rd_next[SRCW:0]  = rd_ctl;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      fiq_n     <= 1'b1;
      irq_n     <= 1'b1;
    end else begin
      bus_rdata <= rd_ok ? rd_next : '0;
      fiq_n     <= ~|fst;
      irq_n     <= ~|ist;
    end
  end

  AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !acc_ok) |=> ($stable(cls_q) && $stable(en_q) && $stable(sw_q)
                             && $stable(def_q) && $stable(guard_q))); // R11
  AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !acc_ok) |=> bus_rdata == '0); // R11
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (wr_ok && hit_vec) |=> !hold_valid); // R10
  AST_HOLD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && hit_vec && win_any && !bus_wr) |=> hold_valid); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == '0); // R12
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam logic [11:0] A_IST = 12'h000, A_FST = 12'h004, A_RAW = 12'h008,
    A_CLS = 12'h00C, A_ENS = 12'h010, A_ENC = 12'h014, A_SWS = 12'h018,
    A_SWC = 12'h01C, A_GRD = 12'h020, A_VEC = 12'h030, A_DEF = 12'h034;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst;
  logic [31:0] irq_req;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd, bus_priv;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fiq_n, irq_n;

  irq_vector_ctrl dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_cls, m_en, m_sw, m_def;
  logic        m_guard, m_hold;
  int          m_hslot;
  logic [31:0] m_addr [16];
  logic [5:0]  m_ctl  [16];

  function automatic logic [31:0] e_raw();  return irq_req | m_sw; endfunction
  function automatic logic [31:0] e_fst();  return e_raw() & m_en & m_cls; endfunction
  function automatic logic [31:0] e_ist();  return e_raw() & m_en & ~m_cls; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_priv = p;
    @(negedge clk);
    bus_wr = 1'b0; bus_priv = 1'b0;
    if (!m_guard || p) begin
      case (a)
        A_CLS: m_cls = d;
        A_ENS: m_en  = m_en | d;
        A_ENC: m_en  = m_en & ~d;
        A_SWS: m_sw  = m_sw | d;
        A_SWC: m_sw  = m_sw & ~d;
        A_GRD: m_guard = d[0];
        A_VEC: m_hold = 1'b0;
        A_DEF: m_def = d;
        default: begin
          if (a >= 12'h100 && a < 12'h140 && a[1:0] == 2'b00) m_addr[(a - 12'h100) >> 2] = d;
          else if (a >= 12'h200 && a < 12'h240 && a[1:0] == 2'b00) m_ctl[(a - 12'h200) >> 2] = d[5:0];
        end
      endcase
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic p, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_priv = p;
    @(negedge clk);
    bus_rd = 1'b0; bus_priv = 1'b0;
    v = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic p, input logic [31:0] e);
    logic [31:0] v;
    rd(a, p, v);
    chk(tag, v, (!m_guard || p) ? e : 32'h0);
  endtask

  task automatic vec_read(input string tag, input logic p);
    logic [31:0] v, e, st;
    int w;
    w = -1;
    st = e_ist();
    for (int i = 0; i < 16; i++)
      if (w < 0 && m_ctl[i][5] && st[m_ctl[i][4:0]] && (!m_hold || i < m_hslot)) w = i;
    if (m_guard && !p)  e = 32'h0;
    else if (w >= 0)    e = m_addr[w];
    else if (m_hold)    e = m_addr[m_hslot];
    else                e = m_def;
    rd(A_VEC, p, v);
    chk(tag, v, e);
    if ((!m_guard || p) && w >= 0) begin m_hold = 1'b1; m_hslot = w; end
  endtask

  task automatic out_chk();
    @(negedge clk);
    chk("R6 fiq_n", {31'h0, fiq_n}, {31'h0, e_fst() == 32'h0});
    chk("R6 irq_n", {31'h0, irq_n}, {31'h0, e_ist() == 32'h0});
  endtask

  task automatic status_chk();
    rd_chk("R2 raw", A_RAW, 1'b1, e_raw());
    rd_chk("R3 fast status", A_FST, 1'b1, e_fst());
    rd_chk("R3 normal status", A_IST, 1'b1, e_ist());
    rd_chk("R3 class", A_CLS, 1'b1, m_cls);
    rd_chk("R4 enable", A_ENS, 1'b1, m_en);
    rd_chk("R5 software", A_SWS, 1'b1, m_sw);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired, all of R1 to R12 unfinished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1F2E3D4C));
    rst = 1'b1; irq_req = '0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0; bus_priv = 0;
    m_cls = 0; m_en = 0; m_sw = 0; m_def = 0; m_guard = 0; m_hold = 0; m_hslot = 0;
    for (int i = 0; i < 16; i++) begin m_addr[i] = 0; m_ctl[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 fiq_n", {31'h0, fiq_n}, 32'h1);
    chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
    chk("R1 rdata", bus_rdata, 32'h0);
    status_chk();
    rd_chk("R1 default", A_DEF, 1'b1, 32'h0);
    rd_chk("R1 slot", 12'h13C, 1'b1, 32'h0);
    vec_read("R1 vector", 1'b1);

    // R12 write-only and unmapped read zero
    wr(A_ENS, 32'hFFFF_0000, 1'b0);
    rd_chk("R12 enable-clear reads 0", A_ENC, 1'b0, 32'h0);
    rd_chk("R12 unmapped", 12'h040, 1'b0, 32'h0);
    rd_chk("R12 unmapped slot gap", 12'h140, 1'b0, 32'h0);

    // R2 status registers are read-only
    irq_req = 32'h0000_00F0;
    wr(A_RAW, 32'hFFFF_FFFF, 1'b0);
    wr(A_IST, 32'hFFFF_FFFF, 1'b0);
    status_chk();

    // R4 R5 directed set/clear, zeros no effect
    wr(A_ENS, 32'h0000_00FF, 1'b0);
    wr(A_ENS, 32'h0, 1'b0);
    wr(A_ENC, 32'h0000_0F00, 1'b0);
    wr(A_SWS, 32'h8000_0001, 1'b0);
    wr(A_SWC, 32'h0000_0001, 1'b0);
    wr(A_SWC, 32'h0, 1'b0);
    status_chk();
    out_chk();

    // R3 R4 R5 R6 random register traffic
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 6));
      case (op)
        0: begin @(negedge clk); irq_req = $urandom() & $urandom(); end
        1: wr(A_CLS, $urandom(), 1'b0);
        2: wr(A_ENS, $urandom() & $urandom(), 1'b0);
        3: wr(A_ENC, $urandom(), 1'b0);
        4: wr(A_SWS, $urandom() & $urandom() & $urandom(), 1'b0);
        5: wr(A_SWC, $urandom(), 1'b0);
        default: status_chk();
      endcase
      out_chk();
    end

    // R7 slot programming
    wr(A_ENC, 32'hFFFF_FFFF, 1'b0);
    wr(A_SWC, 32'hFFFF_FFFF, 1'b0);
    wr(A_CLS, 32'h0, 1'b0);
    @(negedge clk); irq_req = 32'h0;
    wr(A_DEF, 32'hDEAD_0000, 1'b0);
    for (int i = 0; i < 16; i++) begin
      wr(12'h100 + 12'(4 * i), 32'h1000_0000 + 32'(i * 16), 1'b0);
      wr(12'h200 + 12'(4 * i), {26'h3FF_FFFF, (i == 7) ? 1'b0 : 1'b1, 5'((i * 3 + 1) % 32)}, 1'b0);
    end
    for (int i = 0; i < 16; i++) begin
      rd_chk("R7 slot address", 12'h100 + 12'(4 * i), 1'b0, m_addr[i]);
      rd_chk("R7 slot control", 12'h200 + 12'(4 * i), 1'b0, {26'h0, m_ctl[i]});
    end
    wr(A_ENS, 32'hFFFF_FFFF, 1'b0);

    // R8 R9 R10 directed vector sequence
    vec_read("R8 nothing pending gives default", 1'b0);
    @(negedge clk); irq_req = 32'h1 << 22;            // slot 7 source, slot disabled
    vec_read("R8 disabled slot gives default", 1'b0);
    @(negedge clk); irq_req = 32'h1 << 16;            // slot 5 source
    vec_read("R8 slot 5", 1'b0);
    @(negedge clk); irq_req = irq_req | (32'h1 << 28); // slot 9, lower priority
    vec_read("R9 held slot kept", 1'b0);
    @(negedge clk); irq_req = irq_req | (32'h1 << 7);  // slot 2, higher priority
    vec_read("R9 higher slot preempts", 1'b0);
    wr(A_VEC, 32'h0, 1'b0);
    vec_read("R10 after release", 1'b0);
    wr(A_VEC, 32'h1234, 1'b0);
    @(negedge clk); irq_req = irq_req & ~(32'h1 << 7);
    vec_read("R10 next after release", 1'b0);
    wr(A_CLS, 32'h1 << 16, 1'b0);                      // slot 5 source becomes fast
    wr(A_VEC, 32'h0, 1'b0);
    vec_read("R8 fast source not vectored", 1'b0);
    out_chk();

    // R8 R9 R10 random vector traffic
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: begin @(negedge clk); irq_req = $urandom() & $urandom() & $urandom(); end
        1: wr(A_VEC, $urandom(), 1'b0);
        2: wr(A_CLS, $urandom() & $urandom() & $urandom(), 1'b0);
        default: vec_read("R8 random vector", 1'b0);
      endcase
    end
    wr(A_VEC, 32'h0, 1'b0);

    // R11 protection
    wr(A_GRD, 32'h1, 1'b1);
    rd_chk("R11 guard readback", A_GRD, 1'b1, 32'h1);
    wr(A_ENC, 32'hFFFF_FFFF, 1'b0);
    wr(A_DEF, 32'h0BAD_0BAD, 1'b0);
    rd_chk("R11 blocked read", A_ENS, 1'b0, 32'h0);
    rd_chk("R11 enable kept", A_ENS, 1'b1, m_en);
    rd_chk("R11 default kept", A_DEF, 1'b1, m_def);
    vec_read("R11 blocked vector read", 1'b0);
    wr(A_GRD, 32'h0, 1'b0);
    rd_chk("R11 guard still set", A_GRD, 1'b1, 32'h1);
    wr(A_GRD, 32'h0, 1'b1);
    rd_chk("R11 guard cleared", A_GRD, 1'b0, 32'h0);
    out_chk();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule